// File: doc/BRIEF.md
# Bus Tenure Latency Timer Controller

This block bounds how long a bridge may keep ownership of a secondary bus while it acts as initiator. Software programs an 8-bit tenure limit; a counter measures the clocks of the current tenure while the frame signal is asserted. When the count has gone past the limit and the arbiter has taken the grant away, the block raises a disconnect request towards the data path.

Two bus modes exist. In conventional mode every tenure is timed and the request is raised at once. In extended mode only split-completion tenures are timed. The request is held from expiry until the next data phase lands on a 128-byte address boundary. It then drops, and the tenure is not asked to disconnect again.

The limit register is reloaded only by the link reset, with a value that depends on the mode at that time. A secondary bus reset clears the tenure state but keeps the limit.

Top module: `tenure_latency_ctrl`

## Requirements
- R1: The limit register `lat_value` stores bits [7:3] from a write on `lat_wr_en`; bits [2:0] always read as zero (writing 8'hFF reads back 8'hF8).
- R2: While `rst` is high, the limit register loads 8'h40 when `mode_ext` is 1 and 8'h00 when `mode_ext` is 0.
- R3: A `sec_rst` pulse leaves the limit register unchanged.
- R4: The tenure count advances by one on each clock with `frame` high; the timer expires on the clock whose count exceeds the limit (limit 8: the 9th frame clock).
- R5: In conventional mode (`mode_ext`=0) any tenure is timed, and `disc_req` is 1 after the clock edge at which the timer has expired with `gnt` low.
- R6: The count restarts from zero at each rising edge of `frame`, so a new tenure does not inherit the old count.
- R7: A limit of zero expires on the first frame clock of a tenure.
- R8: `disc_req` is 0 after any clock edge at which `gnt` is 1.
- R9: `disc_req` is 0 after any clock edge at which `frame` is 0.
- R10: In extended mode (`mode_ext`=1), tenures with `split_cpl`=0 never raise `disc_req`.
- R11: In extended mode with `split_cpl`=1, `disc_req` rises on expiry and stays 1 until a clock at which `addr[6:0]`==0 while it is 1; after that edge it is 0.
- R12: In extended mode, after a boundary disconnect `disc_req` stays 0 for the rest of that tenure, even though the timer is still expired.
- R13: The count saturates at 255 and does not wrap, so with limit 8'hF8 the request stays asserted past clock 256 of a tenure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Link reset, synchronous, active high |
| sec_rst | input | 1 | Secondary bus reset, synchronous, active high |
| mode_ext | input | 1 | Bus mode: 1 extended, 0 conventional |
| lat_wr_en | input | 1 | Limit register write strobe |
| lat_wr_data | input | 8 | Limit register write data |
| lat_value | output | 8 | Limit register contents |
| frame | input | 1 | Bridge-driven frame asserted (active high) |
| gnt | input | 1 | Arbiter grant to the bridge (active high) |
| split_cpl | input | 1 | Current tenure is a split completion |
| addr | input | 32 | Byte address of the next data phase |
| disc_req | output | 1 | Disconnect request to the data path (registered) |

## Verification
In conventional mode, long tenures with grant low show where expiry falls against the limit. The same tenures with grant held high, and then dropped late, show that grant alone gates the request. Back-to-back tenures with limits of zero and 8 distinguish a counter that restarts from one that carries over. A tenure longer than 256 clocks separates saturation from wrap. In extended mode, a host-initiated tenure and a split completion that walks its address across a 128-byte line show the type filter, the hold until the boundary and the silence after it.

// File: rtl/tenure_pkg.sv
package tenure_pkg;
  typedef enum logic {
    MODE_CONV = 1'b0,
    MODE_EXT  = 1'b1
  } bus_mode_e;
endpackage

// File: rtl/tenure_limit_reg.sv
module tenure_limit_reg
  import tenure_pkg::*;
#(
  parameter int LAT_W = 8,
  parameter int RO_LSB = 3,
  parameter logic [LAT_W-1:0] EXT_INIT = 8'h40,
  parameter logic [LAT_W-1:0] CONV_INIT = 8'h00
) (
  input  logic             clk,
  input  logic             rst,
  input  bus_mode_e        mode,
  input  logic             wr_en,
  input  logic [LAT_W-1:0] wr_data,
  output logic [LAT_W-1:0] value
);
  localparam int RW_W = LAT_W - RO_LSB;

  logic [RW_W-1:0] rw_q;

  // Only the upper field is stored; the low field is hard zero.
  always_ff @(posedge clk) begin
    if (rst) begin
      if (mode == MODE_EXT) rw_q <= EXT_INIT[LAT_W-1:RO_LSB];
      else                  rw_q <= CONV_INIT[LAT_W-1:RO_LSB];
    end else if (wr_en) begin
      rw_q <= wr_data[LAT_W-1:RO_LSB];
    end
  end

  assign value = {rw_q, {RO_LSB{1'b0}}};
endmodule

// File: rtl/tenure_counter.sv
module tenure_counter #(
  parameter int LAT_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sec_rst,
  input  logic             frame,
  input  logic [LAT_W-1:0] limit,
  output logic             expire
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             frame_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_base;
  logic [CNT_W-1:0] cnt_n;
  logic             start;

  assign start    = frame && !frame_q;
  assign cnt_base = start ? '0 : cnt_q;

  always_comb begin
    if (!frame)                  cnt_n = cnt_q;
    else if (cnt_base == CNT_MAX) cnt_n = CNT_MAX;
    else                         cnt_n = cnt_base + 1'b1;
  end

  assign expire = frame && (cnt_n > CNT_W'(limit));

  always_ff @(posedge clk) begin
    if (rst || sec_rst) begin
      frame_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      frame_q <= frame;
      cnt_q   <= cnt_n;
    end
  end
endmodule

// File: rtl/tenure_disc_ctrl.sv
module tenure_disc_ctrl
  import tenure_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BND_BITS = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_rst,
  input  bus_mode_e         mode,
  input  logic              frame,
  input  logic              gnt,
  input  logic              split_cpl,
  input  logic [ADDR_W-1:0] addr,
  input  logic              expire,
  output logic              disc_req
);
  logic disc_q, done_q;
  logic disc_n, done_n;
  logic bnd, active, keep;

  assign bnd    = (addr[BND_BITS-1:0] == '0);
  assign active = (mode == MODE_EXT) ? split_cpl : 1'b1;
  assign keep   = frame && !gnt && active;

  always_comb begin
    if (mode == MODE_EXT) begin
      if (disc_q) disc_n = keep && !bnd;
      else        disc_n = keep && expire && !done_q;
      done_n = frame && (done_q || (disc_q && bnd));
    end else begin
      disc_n = keep && expire;
      done_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || sec_rst) begin
      disc_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      disc_q <= disc_n;
      done_q <= done_n;
    end
  end

  assign disc_req = disc_q;
endmodule

// File: rtl/tenure_latency_ctrl.sv
module tenure_latency_ctrl
  import tenure_pkg::*;
#(
  parameter int LAT_W = 8,
  parameter int RO_LSB = 3,
  parameter int CNT_W = 8,
  parameter int ADDR_W = 32,
  parameter int BND_BITS = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_rst,
  input  logic              mode_ext,
  input  logic              lat_wr_en,
  input  logic [LAT_W-1:0]  lat_wr_data,
  output logic [LAT_W-1:0]  lat_value,
  input  logic              frame,
  input  logic              gnt,
  input  logic              split_cpl,
  input  logic [ADDR_W-1:0] addr,
  output logic              disc_req
);
  bus_mode_e mode;
  logic      expire;

  assign mode = mode_ext ? MODE_EXT : MODE_CONV;

  tenure_limit_reg #(.LAT_W(LAT_W), .RO_LSB(RO_LSB)) u_limit (
    .clk(clk), .rst(rst), .mode(mode),
    .wr_en(lat_wr_en), .wr_data(lat_wr_data), .value(lat_value)
  );

  tenure_counter #(.LAT_W(LAT_W), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .sec_rst(sec_rst), .frame(frame),
    .limit(lat_value), .expire(expire)
  );

  tenure_disc_ctrl #(.ADDR_W(ADDR_W), .BND_BITS(BND_BITS)) u_disc (
    .clk(clk), .rst(rst), .sec_rst(sec_rst), .mode(mode),
    .frame(frame), .gnt(gnt), .split_cpl(split_cpl), .addr(addr),
    .expire(expire), .disc_req(disc_req)
  );
endmodule

// File: rtl/tenure_latency_ctrl_chk.sv
module tenure_latency_ctrl_chk #(
  parameter int LAT_W = 8,
  parameter int RO_LSB = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             sec_rst,
  input logic             mode_ext,
  input logic             lat_wr_en,
  input logic [LAT_W-1:0] lat_value,
  input logic             frame,
  input logic             gnt,
  input logic             split_cpl,
  input logic             disc_req
);
  assert_ro_zero_R1: assert property (@(posedge clk) disable iff (rst)
    lat_value[RO_LSB-1:0] == '0);

  assert_link_reset_R2: assert property (@(posedge clk)
    rst |=> (lat_value == ($past(mode_ext) ? LAT_W'(8'h40) : LAT_W'(8'h00))));

  assert_sec_keeps_limit_R3: assert property (@(posedge clk) disable iff (rst)
    (sec_rst && !lat_wr_en) |=> $stable(lat_value));

  assert_grant_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    gnt |=> !disc_req);

  assert_frame_clears_R9: assert property (@(posedge clk) disable iff (rst)
    !frame |=> !disc_req);

  assert_host_untimed_R10: assert property (@(posedge clk) disable iff (rst)
    (mode_ext && !split_cpl) |=> !disc_req);
endmodule

bind tenure_latency_ctrl tenure_latency_ctrl_chk #(.LAT_W(LAT_W), .RO_LSB(RO_LSB)) u_chk (
  .clk(clk), .rst(rst), .sec_rst(sec_rst), .mode_ext(mode_ext),
  .lat_wr_en(lat_wr_en), .lat_value(lat_value), .frame(frame),
  .gnt(gnt), .split_cpl(split_cpl), .disc_req(disc_req)
);

// File: tb/tenure_latency_ctrl_tb.sv
module tenure_latency_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sec_rst = 1'b0;
  logic        mode_ext = 1'b0;
  logic        lat_wr_en = 1'b0;
  logic [7:0]  lat_wr_data = '0;
  logic [7:0]  lat_value;
  logic        frame = 1'b0;
  logic        gnt = 1'b0;
  logic        split_cpl = 1'b0;
  logic [31:0] addr = '0;
  logic        disc_req;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic  exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  tenure_latency_ctrl u_dut (
    .clk(clk), .rst(rst), .sec_rst(sec_rst), .mode_ext(mode_ext),
    .lat_wr_en(lat_wr_en), .lat_wr_data(lat_wr_data), .lat_value(lat_value),
    .frame(frame), .gnt(gnt), .split_cpl(split_cpl), .addr(addr),
    .disc_req(disc_req)
  );

  // Monitor: compares the registered request just after each edge.
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (disc_req !== e) begin
        errors++;
        $display("FAIL %s disc_req actual %b expected %b", t, disc_req, e);
      end
    end
  end

  task automatic check_lat(input logic [7:0] e, input string t);
    checks++;
    if (lat_value !== e) begin
      errors++;
      $display("FAIL %s lat_value actual %h expected %h", t, lat_value, e);
    end
  endtask

  // Driver: applies one clock of stimulus and queues the expected request.
  task automatic step(input logic f, input logic g, input logic s,
                      input logic [31:0] a, input logic e, input string t);
    frame = f; gnt = g; split_cpl = s; addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v);
    lat_wr_en = 1'b1; lat_wr_data = v;
    @(negedge clk);
    lat_wr_en = 1'b0;
  endtask

  task automatic idle();
    step(1'b0, 1'b0, 1'b0, 32'h0, 1'b0, "R9");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    mode_ext = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check_lat(8'h00, "R2 conventional");
    mode_ext = 1'b1; rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check_lat(8'h40, "R2 extended");

    wr(8'hFF);
    check_lat(8'hF8, "R1");
    sec_rst = 1'b1; @(negedge clk); sec_rst = 1'b0;
    check_lat(8'hF8, "R3");

    // Conventional mode, limit 8, two back-to-back tenures.
    mode_ext = 1'b0;
    wr(8'h08);
    for (int i = 1; i <= 12; i++) step(1'b1, 1'b0, 1'b0, 32'h0, i > 8, "R4 R5");
    idle();
    for (int i = 1; i <= 12; i++) step(1'b1, 1'b0, 1'b0, 32'h0, i > 8, "R6");
    idle();

    // Grant held, then withdrawn late.
    for (int i = 1; i <= 11; i++) step(1'b1, 1'b1, 1'b0, 32'h0, 1'b0, "R8");
    step(1'b1, 1'b0, 1'b0, 32'h0, 1'b1, "R5 late grant drop");
    idle();

    // Zero limit.
    wr(8'h00);
    step(1'b1, 1'b0, 1'b0, 32'h0, 1'b1, "R7");
    idle();

    // Saturation with limit F8.
    wr(8'hFF);
    for (int i = 1; i <= 300; i++) step(1'b1, 1'b0, 1'b0, 32'h0, i > 248, "R13");
    idle();

    // Extended mode, host-initiated tenure is untimed.
    mode_ext = 1'b1;
    wr(8'h08);
    for (int i = 1; i <= 15; i++) step(1'b1, 1'b0, 1'b0, 32'h0, 1'b0, "R10");
    idle();

    // Extended split completion: expiry at 9, boundary 0x180 at step 14.
    for (int i = 1; i <= 18; i++) begin
      logic e;
      e = (i >= 9) && (i <= 13);
      step(1'b1, 1'b0, 1'b1, 32'h148 + 32'(4 * i), e, i <= 14 ? "R11" : "R12");
    end
    idle();
    idle();

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule